// File: doc/BRIEF.md
# Set-Associative Load Violation Filter

This block is a second-level load tracker that runs only while a long-latency cache miss is outstanding. During that time, loads that execute ahead of older work report their addresses to it. It files each address into one set of a small set-associative array, chosen directly from index bits of the address. The array keeps no record of which load came first, and no lookup ever searches the whole array.

Every store that completes during the miss shadow is snooped against the single set its address selects. A match on a recorded 8-byte granule raises a sticky violation flag. The surrounding core treats this flag as a request to roll back to its most recent checkpoint. The flag says only that a conflict occurred. It does not say which load caused it.

A set can run out of ways. When a load cannot be recorded, the block raises the violation flag anyway, so no conflict is ever missed. A checkpoint-clear pulse empties the whole array in one cycle and lowers both flags.

Top module: `ldviol_filter`

## Requirements
- R1: After reset, `violation` and `set_full` are low and no address is recorded.
- R2: While `miss_active` is low, load inserts and store snoops are ignored, and every recorded entry is dropped. Two consequences follow:
  - A load presented while idle is not flagged by a later store once the miss is active.
  - A load recorded before `miss_active` fell is not flagged by a later store once the miss is active again.
- R3: Each load or store address is split into three fields:
  - Bits [2:0] are the byte offset and are not compared, so matching is at 8-byte granularity.
  - Bits [8:3] select one of the 64 sets.
  - Bits [31:9] form the tag.
  - A store whose set index or tag differs from every recorded load does not raise `violation`.
- R4: A store whose set and tag match a recorded load raises `violation` on the clock edge that samples the store.
- R5: `violation` stays high until a checkpoint-clear pulse, whatever other inputs arrive.
- R6: A `ckpt_clear` pulse does three things on the edge that samples it:
  - It invalidates every entry.
  - It lowers `violation` and `set_full`.
  - It overrides any load or store presented in the same cycle.
- R7: Each set holds 4 distinct granules. A load with a fifth distinct tag in the same set raises both `violation` and `set_full`. Loads to other sets are unaffected.
- R8: A load to a granule that its set already holds does not use up a way.
- R9: A store and a load in the same cycle are resolved snoop-first. The store is compared with the set contents before that load is written. A load to the same granule in that cycle is recorded but not flagged by that store. A same-cycle store to an earlier recorded load in the same set is still flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_active | input | 1 | High while a long-latency miss is outstanding; enables the block |
| ckpt_clear | input | 1 | One-cycle pulse that empties the array and clears both flags |
| ld_valid | input | 1 | A load address is presented for recording |
| ld_addr | input | 32 | Byte address of the load |
| st_valid | input | 1 | A completed store address is presented for snooping |
| st_addr | input | 32 | Byte address of the store |
| violation | output | 1 | Sticky rollback request: conflict found or a load could not be recorded |
| set_full | output | 1 | Sticky: some load found its set with no free way |

## Verification
The bench uses the default parameters:
- 32-bit addresses.
- An 8-byte granule.
- 64 sets of 4 ways.

With only 4 ways, five loads to one set are enough to reach the overflow path. A duplicate-granule load and a load into a neighbouring set can be placed among them to show that neither uses up a way. With 64 sets, a store can differ from a recorded load only in index, only in tag, or only in byte offset, which tests each field of the address split on its own. Same-cycle load and store pairs test the snoop-first ordering. Clear pulses that carry a store in the same cycle test the priority of checkpoint clear.

// File: rtl/ldvf_pkg.sv
package ldvf_pkg;
    // Outcome of presenting one load to its set
    typedef enum logic [1:0] {
        INS_NONE     = 2'd0,
        INS_DUP      = 2'd1,
        INS_ALLOC    = 2'd2,
        INS_OVERFLOW = 2'd3
    } ins_kind_e;
endpackage

// File: rtl/ldvf_addr_split.sv
module ldvf_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 3,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic [IDX_W-1:0]              idx,
    output logic [ADDR_W-OFS_W-IDX_W-1:0] tag
);
    logic unused_ofs;

    assign idx        = addr[OFS_W+IDX_W-1:OFS_W];
    assign tag        = addr[ADDR_W-1:OFS_W+IDX_W];
    assign unused_ofs = ^addr[OFS_W-1:0];
endmodule

// File: rtl/ldvf_set_match.sv
module ldvf_set_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23
) (
    input  logic [WAYS-1:0]            row_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            hit,
    output logic [WAYS-1:0]            free
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w]  = row_vld[w] && (row_tag[w] == key);
        assign free[w] = !row_vld[w];
    end
endmodule

// File: rtl/ldvf_first_free.sv
module ldvf_first_free #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0] free,
    output logic [WAYS-1:0] grant,
    output logic            any
);
    for (genvar w = 0; w < WAYS; w++) begin : g_pick
        localparam logic [WAYS-1:0] BELOW = WAYS'((1 << w) - 1);
        assign grant[w] = free[w] && ((free & BELOW) == '0);
    end
    assign any = |free;
endmodule

// File: rtl/ldviol_filter.sv
module ldviol_filter
    import ldvf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRAN_W = 3,
    parameter int SETS   = 64,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_active,
    input  logic              ckpt_clear,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              violation,
    output logic              set_full
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - GRAN_W - IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic                                 viol;
        logic                                 full;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0] ld_idx, st_idx;
    logic [TAG_W-1:0] ld_tag, st_tag;
    logic [WAYS-1:0]  ld_hit, ld_free, ld_grant;
    logic [WAYS-1:0]  st_hit, st_free_unused;
    logic             ld_any_free;
    ins_kind_e        ins_kind;

    ldvf_addr_split #(.ADDR_W(ADDR_W), .OFS_W(GRAN_W), .IDX_W(IDX_W)) u_ld_split (
        .addr (ld_addr),
        .idx  (ld_idx),
        .tag  (ld_tag)
    );

    ldvf_addr_split #(.ADDR_W(ADDR_W), .OFS_W(GRAN_W), .IDX_W(IDX_W)) u_st_split (
        .addr (st_addr),
        .idx  (st_idx),
        .tag  (st_tag)
    );

    // Both lookups read the registered set, so the snoop sees pre-insert contents
    ldvf_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ld_match (
        .row_vld (state_q.vld[ld_idx]),
        .row_tag (state_q.tag[ld_idx]),
        .key     (ld_tag),
        .hit     (ld_hit),
        .free    (ld_free)
    );

    ldvf_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_st_match (
        .row_vld (state_q.vld[st_idx]),
        .row_tag (state_q.tag[st_idx]),
        .key     (st_tag),
        .hit     (st_hit),
        .free    (st_free_unused)
    );

    ldvf_first_free #(.WAYS(WAYS)) u_pick (
        .free  (ld_free),
        .grant (ld_grant),
        .any   (ld_any_free)
    );

    always_comb begin
        if (!ld_valid || !miss_active) begin
            ins_kind = INS_NONE;
        end else if (|ld_hit) begin
            ins_kind = INS_DUP;
        end else if (ld_any_free) begin
            ins_kind = INS_ALLOC;
        end else begin
            ins_kind = INS_OVERFLOW;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ckpt_clear) begin
            state_d.vld  = '0;
            state_d.viol = 1'b0;
            state_d.full = 1'b0;
        end else if (!miss_active) begin
            state_d.vld = '0;
        end else begin
            if (st_valid && (|st_hit)) begin
                state_d.viol = 1'b1;
            end
            case (ins_kind)
                INS_ALLOC: begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (ld_grant[w]) begin
                            state_d.vld[ld_idx][w] = 1'b1;
                            state_d.tag[ld_idx][w] = ld_tag;
                        end
                    end
                end
                INS_OVERFLOW: begin
                    state_d.viol = 1'b1;
                    state_d.full = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign violation = state_q.viol;
    assign set_full  = state_q.full;
endmodule

// File: rtl/ldvf_checker.sv
module ldvf_checker (
    input logic clk,
    input logic rst_n,
    input logic miss_active,
    input logic ckpt_clear,
    input logic violation,
    input logic set_full
);
    // R6: a clear pulse leaves both flags low on the following cycle
    p_clear_lowers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_clear |=> (!violation && !set_full));

    // R5: the violation flag holds until cleared
    p_viol_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !ckpt_clear) |=> violation);

    // R7: an overflow always also requests rollback
    p_full_means_viol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_full |-> violation);

    // R7: the overflow indication holds until cleared
    p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_full && !ckpt_clear) |=> set_full);

    // R2: no new violation is raised while idle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_active && !violation) |=> !violation);

    // R2: no new overflow is raised while idle
    p_idle_no_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_active && !set_full) |=> !set_full);
endmodule

bind ldviol_filter ldvf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_active (miss_active),
    .ckpt_clear  (ckpt_clear),
    .violation   (violation),
    .set_full    (set_full)
);

// File: tb/ldviol_filter_bench.sv
module ldviol_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_active = 1'b0;
    logic        ckpt_clear = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        violation;
    logic        set_full;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldviol_filter u_ldviol_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_active (miss_active),
        .ckpt_clear  (ckpt_clear),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .st_valid    (st_valid),
        .st_addr     (st_addr),
        .violation   (violation),
        .set_full    (set_full)
    );

    // Address: tag in [31:9], set in [8:3], byte offset in [2:0]
    function automatic logic [31:0] mk(input int tag, input int set, input int ofs);
        logic [31:0] a;
        a[31:9] = tag[22:0];
        a[8:3]  = set[5:0];
        a[2:0]  = ofs[2:0];
        return a;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle of stimulus; results are visible when the task returns
    task automatic step(input logic m, input logic lv, input logic [31:0] la,
                        input logic sv, input logic [31:0] sa, input logic clr);
        @(negedge clk);
        miss_active = m;
        ld_valid    = lv;
        ld_addr     = la;
        st_valid    = sv;
        st_addr     = sa;
        ckpt_clear  = clr;
        @(negedge clk);
        ld_valid   = 1'b0;
        st_valid   = 1'b0;
        ckpt_clear = 1'b0;
    endtask

    task automatic clear_all();
        step(1'b1, 1'b0, '0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 violation after reset", violation, 1'b0);
        chk("R1 set_full after reset", set_full, 1'b0);
    endtask

    task automatic t_match();
        clear_all();
        step(1'b1, 1'b1, mk(5, 10, 0), 1'b0, '0, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(6, 10, 0), 1'b0);
        chk("R3 other tag same set", violation, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(5, 11, 0), 1'b0);
        chk("R3 same tag other set", violation, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(5, 10, 7), 1'b0);
        chk("R3 R4 same granule other byte", violation, 1'b1);
        chk("R4 no overflow on hit", set_full, 1'b0);
    endtask

    task automatic t_sticky_clear();
        step(1'b1, 1'b1, mk(40, 3, 0), 1'b0, '0, 1'b0);
        step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(99, 9, 0), 1'b0);
        chk("R5 violation held", violation, 1'b1);
        clear_all();
        chk("R6 clear lowers violation", violation, 1'b0);
        step(1'b1, 1'b1, mk(7, 12, 0), 1'b0, '0, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(7, 12, 0), 1'b1);
        chk("R6 clear overrides same-cycle store", violation, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(7, 12, 0), 1'b0);
        chk("R6 entries emptied by clear", violation, 1'b0);
    endtask

    task automatic t_idle();
        clear_all();
        step(1'b0, 1'b1, mk(8, 14, 0), 1'b0, '0, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(8, 14, 0), 1'b0);
        chk("R2 idle load not recorded", violation, 1'b0);
        step(1'b1, 1'b1, mk(9, 15, 0), 1'b0, '0, 1'b0);
        step(1'b0, 1'b0, '0, 1'b1, mk(9, 15, 0), 1'b0);
        chk("R2 idle store ignored", violation, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(9, 15, 0), 1'b0);
        chk("R2 entries dropped when idle", violation, 1'b0);
    endtask

    task automatic t_capacity();
        clear_all();
        for (int t = 1; t <= 4; t++) begin
            step(1'b1, 1'b1, mk(t, 20, 0), 1'b0, '0, 1'b0);
        end
        step(1'b1, 1'b1, mk(1, 20, 4), 1'b0, '0, 1'b0);
        chk("R8 duplicate uses no way", set_full, 1'b0);
        step(1'b1, 1'b1, mk(9, 21, 0), 1'b0, '0, 1'b0);
        chk("R7 other set unaffected", set_full, 1'b0);
        chk("R7 four ways fit", violation, 1'b0);
        step(1'b1, 1'b1, mk(5, 20, 0), 1'b0, '0, 1'b0);
        chk("R7 fifth tag sets full", set_full, 1'b1);
        chk("R7 fifth tag sets violation", violation, 1'b1);
        clear_all();
        chk("R6 clear lowers full", set_full, 1'b0);
    endtask

    task automatic t_snoop_first();
        clear_all();
        step(1'b1, 1'b1, mk(33, 30, 0), 1'b1, mk(33, 30, 0), 1'b0);
        chk("R9 same-cycle pair not flagged", violation, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1, mk(33, 30, 2), 1'b0);
        chk("R9 same-cycle load was recorded", violation, 1'b1);
        clear_all();
        step(1'b1, 1'b1, mk(50, 31, 0), 1'b0, '0, 1'b0);
        step(1'b1, 1'b1, mk(51, 31, 0), 1'b1, mk(50, 31, 0), 1'b0);
        chk("R9 older load still flagged", violation, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_match();
        t_sticky_clear();
        t_idle();
        t_capacity();
        t_snoop_first();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule